// File: doc/BRIEF.md
# Bit-Serial PHY Configuration Receiver

This block is the receiving end of a bit-serial configuration channel for a PHY. A writer drives an 8-bit bit-address bus and a single data line that are shared by several PHY instances. Each instance has its own strobe line. The block keeps a 256-bit configuration store. Every rising edge on the strobe that belongs to this instance writes the data line into exactly one bit of the store, at the position the address bus names. The whole store is offered as a parallel vector to the PHY control logic around it.

The strobe is asynchronous to the local clock. The block brings it through a two-stage synchroniser and then detects its rising edge. Address and data are taken from the bus in the cycle the edge is detected, which works because the writer keeps them steady for as long as the strobe is high. A wider field is loaded as a run of single-bit writes at rising addresses, least significant bit first. A parameter chooses which of the three strobe lines the instance answers to, and a second parameter sets the value the store takes on reset.

Top module: `phyBitCfgRx`

## Requirements
- R1: While reset is asserted, and right after it is released, `cfgVector` equals the parameter `RESET_VALUE`.
- R2: A rising edge on strobe line `STROBE_SEL` writes `bitData` into `cfgVector[bitAddr]`. All other bits of the store keep their values.
- R3: Activity on the strobe lines other than `STROBE_SEL` leaves the store unchanged.
- R4: Changes on `bitAddr` and `bitData` while no strobe edge is seen leave the store unchanged.
- R5: One strobe pulse writes exactly once. If address or data change while the strobe is still held high after its edge, the store does not change again.
- R6: An N-bit field written LSB first at addresses A, A+1, ..., A+N-1 appears in `cfgVector[A+N-1:A]` as its binary value.
- R7: Latency. When the strobe is seen high at clock edge k, the store is unchanged after edge k+1 and holds the new bit after edge k+2.
- R8: Any address from 0 to 255 can be written, including both ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitAddr | input | 8 | Bit position to write |
| bitData | input | 1 | Value of the bit to write |
| strobeLines | input | 3 | Asynchronous write strobes, one per PHY instance |
| cfgVector | output | 256 | Parallel view of the configuration store |

## Verification
The in-RTL assertions check on every cycle that a write command changes at most one bit of the store, that it lands the captured data at the captured address, that the store holds when no command is issued, and that one strobe pulse never yields two back-to-back commands. Only the bench scenarios can show that the right strobe line is selected, what the store's reset contents are, the exact latency from strobe to store, how LSB-first fields assemble, and whether the end addresses can be reached. The bench covers these with random writes on all three lines plus directed cases.

// File: rtl/phyBitCfgPkg.sv
package phyBitCfgPkg;
  parameter int ADDR_W = 8;
  localparam int STORE_BITS = 1 << ADDR_W;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic              data;
  } cfgWrCmd_t;
endpackage

// File: rtl/phyBitCfgCtrl.sv
module phyBitCfgCtrl
  import phyBitCfgPkg::*;
#(
  parameter int NUM_STROBES = 3,
  parameter int STROBE_SEL  = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      bitAddr,
  input  logic                   bitData,
  input  logic [NUM_STROBES-1:0] strobeLines,
  output cfgWrCmd_t              wrCmd
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   strobePrev;
  logic                   strobeSynced;

  assign strobeSynced = syncChain[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= strobeLines[STROBE_SEL];
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], strobeLines[STROBE_SEL]};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) strobePrev <= 1'b0;
    else       strobePrev <= strobeSynced;
  end

  always_comb begin
    wrCmd.wrEn = strobeSynced & ~strobePrev;
    wrCmd.addr = bitAddr;
    wrCmd.data = bitData;
  end

  AST_SINGLE_WRITE_PER_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd.wrEn |=> !wrCmd.wrEn); // R5
endmodule

// File: rtl/phyBitCfgStore.sv
module phyBitCfgStore
  import phyBitCfgPkg::*;
#(
  parameter logic [STORE_BITS-1:0] RESET_VALUE = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgWrCmd_t             wrCmd,
  output logic [STORE_BITS-1:0] store
);
  always_ff @(posedge clk) begin
    if (!rstN)
      store <= RESET_VALUE;
    else if (wrCmd.wrEn)
      store[wrCmd.addr] <= wrCmd.data;
  end

  AST_ONE_BIT_CHANGED: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd.wrEn |=> $countones(store ^ $past(store)) <= 1); // R2
  AST_BIT_LANDED: assert property (@(posedge clk) disable iff (!rstN)
    wrCmd.wrEn |=> store[$past(wrCmd.addr)] == $past(wrCmd.data)); // R2
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrCmd.wrEn |=> $stable(store)); // R4
endmodule

// File: rtl/phyBitCfgRx.sv
module phyBitCfgRx
  import phyBitCfgPkg::*;
#(
  parameter int NUM_STROBES = 3,
  parameter int STROBE_SEL  = 0,
  parameter logic [STORE_BITS-1:0] RESET_VALUE = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      bitAddr,
  input  logic                   bitData,
  input  logic [NUM_STROBES-1:0] strobeLines,
  output logic [STORE_BITS-1:0]  cfgVector
);
  cfgWrCmd_t wrCmd;

  phyBitCfgCtrl #(
    .NUM_STROBES(NUM_STROBES),
    .STROBE_SEL (STROBE_SEL),
    .SYNC_STAGES(2)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitAddr    (bitAddr),
    .bitData    (bitData),
    .strobeLines(strobeLines),
    .wrCmd      (wrCmd)
  );

  phyBitCfgStore #(
    .RESET_VALUE(RESET_VALUE)
  ) i_store (
    .clk  (clk),
    .rstN (rstN),
    .wrCmd(wrCmd),
    .store(cfgVector)
  );
endmodule

// File: tb/test_phyBitCfgRx.sv
module test_phyBitCfgRx;
  localparam int CLK_PERIOD = 10;
  localparam int SEL = 1;
  localparam logic [255:0] RST_VAL = {8{32'hA5C3_0F96}};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   bitAddr = '0;
  logic         bitData = 1'b0;
  logic [2:0]   strobeLines = '0;
  logic [255:0] cfgVector;

  logic [255:0] model;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phyBitCfgRx #(.NUM_STROBES(3), .STROBE_SEL(SEL), .RESET_VALUE(RST_VAL)) i_phyBitCfgRx (
    .clk(clk), .rstN(rstN), .bitAddr(bitAddr), .bitData(bitData),
    .strobeLines(strobeLines), .cfgVector(cfgVector));

  function automatic logic [255:0] applyWrite(logic [255:0] cur, int line, logic [7:0] a, logic d);
    logic [255:0] r = cur;
    if (line == SEL) r[a] = d;
    return r;
  endfunction

  task automatic checkVec(string req, logic [255:0] exp);
    checks++;
    if (cfgVector !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, cfgVector, exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic doWrite(int line, logic [7:0] a, logic d);
    @(negedge clk); bitAddr = a; bitData = d;
    @(negedge clk); strobeLines[line] = 1'b1;
    repeat (4) @(negedge clk);
    strobeLines[line] = 1'b0;
    repeat (3) @(negedge clk);
    model = applyWrite(model, line, a, d);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    model = RST_VAL;
    repeat (3) @(negedge clk);
    checkVec("R1 during reset", RST_VAL);
    rstN = 1'b1;
    @(negedge clk);
    checkVec("R1 after reset", RST_VAL);

    // R7 latency: strobe seen at edge k, stable after k+1, written after k+2
    @(negedge clk); bitAddr = 8'd17; bitData = ~model[17];
    @(negedge clk); strobeLines[SEL] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checkVec("R7 no change after one synchroniser stage", model);
    @(negedge clk);
    model[17] = ~model[17];
    checkVec("R7 written after second stage", model);
    // R5: change bus while strobe still high
    bitAddr = 8'd18; bitData = ~model[18];
    repeat (4) @(negedge clk);
    checkVec("R5 no second write while held high", model);
    strobeLines[SEL] = 1'b0;
    repeat (3) @(negedge clk);
    checkVec("R5 no write on falling edge", model);

    // R4: bus wiggle with strobe low
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); bitAddr = 8'($urandom); bitData = 1'($urandom);
    end
    repeat (2) @(negedge clk);
    checkVec("R4 bus changes without strobe", model);

    // R3: other lines ignored
    doWrite(0, 8'd5, ~model[5]);
    checkVec("R3 strobe line 0 ignored", model);
    doWrite(2, 8'd6, ~model[6]);
    checkVec("R3 strobe line 2 ignored", model);

    // R8: end addresses
    doWrite(SEL, 8'd0, ~model[0]);
    checkVec("R8 address 0", model);
    doWrite(SEL, 8'd255, ~model[255]);
    checkVec("R8 address 255", model);

    // R6: LSB-first field 0xB6 at address 40
    for (int i = 0; i < 8; i++) doWrite(SEL, 8'(40 + i), 1'((8'hB6 >> i) & 1));
    checks++;
    if (cfgVector[47:40] !== 8'hB6) begin
      failures++;
      $display("FAIL R6 field actual=%h expected=b6", cfgVector[47:40]);
    end

    // R2 and R3 random writes across all lines
    for (int n = 0; n < 150; n++) begin
      int line = int'($urandom_range(0, 2));
      logic [7:0] a = 8'($urandom);
      logic d = 1'($urandom);
      doWrite(line, a, d);
      checkVec(line == SEL ? "R2 random own write" : "R3 random foreign write", model);
      checkBit("R2 target bit", cfgVector[a], model[a]);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule